// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the command path of a mobile DDR memory model. It holds a small mode register and expands each READ or WRITE start column into the column address of every beat of the burst, one address per clock. The register sets the burst length, the order of the beats (sequential or interleaved) and the CAS latency. The latency is decoded and passed on to the data-path logic.

The register is written with a load strobe that carries an address field and a bank field. A load takes effect only when the bank field is zero, the reserved upper address bits are zero and every bank is idle. A load made while a bank is busy, or with reserved bits set, raises an error pulse and is ignored. Entering deep power-down returns the register to its reset contents.

A burst never leaves the aligned block of columns whose size equals the burst length. The beats wrap at the block edge. A command with a reserved length code raises an error pulse and produces no beats.

Top module: `burst_col_seq`

## Requirements
- R1: A load with `mrs_en` high, `mrs_bank` zero, `banks_idle` high, `mrs_addr[10:7]` zero and `dpd` low stores `mrs_addr[6:0]`. The new decoded values appear in the cycle after the load edge.
- R2: A load with a zero bank field that has `banks_idle` low, or any of `mrs_addr[10:7]` set, pulses `mrs_err` for one cycle after the load edge and leaves the register unchanged.
- R3: A load with a nonzero `mrs_bank` changes nothing and raises no error.
- R4: While `dpd` is high the register clears to its reset contents and any burst in flight stops. `col_valid` and `cas_lat` read 0 in the following cycle.
- R5: `cas_lat` is 2 for latency code `mrs_addr[6:4]`=010, 3 for code 011, and 0 for every other code.
- R6: Length codes in `mrs_addr[2:0]` are 001=2, 010=4, 011=8 and 100=16 beats. A command issued under any other code pulses `bl_err`, ends any burst in flight and produces no valid beat.
- R7: The cycle after an accepted command carries beat 0, which equals the start column. `col_valid` then stays high for exactly BL consecutive cycles, and `col_last` is high only on the final beat.
- R8: With `mrs_addr[3]`=0 (sequential), the low log2(BL) bits of beat i are (start + i) mod BL.
- R9: With `mrs_addr[3]`=1 (interleaved), the low log2(BL) bits of beat i are start XOR i.
- R10: Column bits 7 down to log2(BL) of every beat equal those of the start column, so the burst wraps inside its aligned block.
- R11: A command that arrives while a burst is running abandons the old burst and starts the new one in the next cycle.
- R12: After reset, `col_valid`, `col_last`, `mrs_err`, `bl_err` and `cas_lat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_en | input | 1 | Mode register load strobe |
| mrs_addr | input | 11 | Load address field: length, order, latency, reserved bits |
| mrs_bank | input | 2 | Load bank field; must be zero to select the register |
| banks_idle | input | 1 | High when every bank is idle |
| dpd | input | 1 | Deep power-down active |
| cmd_en | input | 1 | READ or WRITE command strobe |
| cmd_col | input | 8 | Start column of the command |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Current beat is the final beat |
| cas_lat | output | 2 | Decoded CAS latency (2, 3, or 0 if reserved) |
| mrs_err | output | 1 | Illegal load pulse |
| bl_err | output | 1 | Command under reserved length pulse |

## Verification
The checker asserts on every cycle the rules that hold at any moment:
- the last flag only marks a valid beat;
- a burst stops after its last beat unless a new command arrives;
- the upper column bits stay fixed within a burst;
- error pulses never coincide with a beat or a latency change;
- deep power-down clears the outputs;
- the latency output stays within its legal set.

Only the bench scenarios can show the following:
- the exact beat order for each length and order;
- the burst length in cycles;
- the restart on a fresh command;
- that illegal loads really leave the stored mode untouched.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam int MODE_W  = 7;
  localparam int MAX_LOG = 4;
  localparam int LOG_W   = 3;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_INTL = 1'b1} order_e;

  typedef struct packed {
    logic [2:0] cl_code;
    order_e     order;
    logic [2:0] bl_code;
  } mode_t;

  function automatic logic [LOG_W-1:0] len_log(input logic [2:0] code);
    case (code)
      3'b001:  return 3'd1;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      3'b100:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] lat_cycles(input logic [2:0] code);
    case (code)
      3'b010:  return 2'd2;
      3'b011:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
`timescale 1ns/1ps
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int MR_W = 11,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mrs_en,
  input  logic [MR_W-1:0] mrs_addr,
  input  logic [BA_W-1:0] mrs_bank,
  input  logic            banks_idle,
  input  logic            dpd,
  output mode_t           mode,
  output logic            load_err
);
  localparam int RSV_W = MR_W - MODE_W;

  logic              sel;
  logic [RSV_W-1:0]  rsv_bits;

  assign sel      = mrs_en && (mrs_bank == '0);
  assign rsv_bits = mrs_addr[MR_W-1:MODE_W];

  always_ff @(posedge clk) begin
    if (rst || dpd) begin
      mode     <= '0;
      load_err <= 1'b0;
    end else begin
      load_err <= 1'b0;
      if (sel) begin
        if (!banks_idle || (rsv_bits != '0)) begin
          load_err <= 1'b1;
        end else begin
          mode <= mode_t'(mrs_addr[MODE_W-1:0]);
        end
      end
    end
  end
endmodule

// File: rtl/bcs_beat_gen.sv
`timescale 1ns/1ps
module bcs_beat_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dpd,
  input  logic             cmd_en,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       bl_code,
  input  order_e           order,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             bl_err
);
  localparam int CNT_W = MAX_LOG + 1;

  logic [LOG_W-1:0] blog;
  logic             legal;
  logic [COL_W-1:0] new_mask;

  logic             active;
  order_e           ord_q;
  logic [COL_W-1:0] base_q, start_q, mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] cnt_col, low_next;

  assign blog     = len_log(bl_code);
  assign legal    = (blog != '0);
  assign new_mask = (COL_W'(1) << blog) - COL_W'(1);
  assign cnt_col  = COL_W'(cnt_q);

  always_comb begin
    if (ord_q == ORD_INTL) low_next = (start_q ^ cnt_col) & mask_q;
    else                   low_next = (start_q + cnt_col) & mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst || dpd) begin
      active    <= 1'b0;
      ord_q     <= ORD_SEQ;
      base_q    <= '0;
      start_q   <= '0;
      mask_q    <= '0;
      cnt_q     <= '0;
      col_out   <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      bl_err    <= 1'b0;
    end else begin
      bl_err <= 1'b0;
      if (cmd_en) begin
        if (legal) begin
          active    <= 1'b1;
          ord_q     <= order;
          base_q    <= cmd_col & ~new_mask;
          start_q   <= cmd_col & new_mask;
          mask_q    <= new_mask;
          cnt_q     <= CNT_W'(1);
          col_out   <= cmd_col;
          col_valid <= 1'b1;
          col_last  <= 1'b0;
        end else begin
          active    <= 1'b0;
          bl_err    <= 1'b1;
          col_valid <= 1'b0;
          col_last  <= 1'b0;
        end
      end else if (active) begin
        col_out   <= base_q | low_next;
        col_valid <= 1'b1;
        col_last  <= (cnt_col == mask_q);
        cnt_q     <= cnt_q + CNT_W'(1);
        if (cnt_col == mask_q) active <= 1'b0;
      end else begin
        col_valid <= 1'b0;
        col_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int MR_W  = 11,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mrs_en,
  input  logic [MR_W-1:0]  mrs_addr,
  input  logic [BA_W-1:0]  mrs_bank,
  input  logic             banks_idle,
  input  logic             dpd,
  input  logic             cmd_en,
  input  logic [COL_W-1:0] cmd_col,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic             mrs_err,
  output logic             bl_err
);
  mode_t mode;

  bcs_mode_reg #(.MR_W(MR_W), .BA_W(BA_W)) u_mode (
    .clk(clk), .rst(rst), .mrs_en(mrs_en), .mrs_addr(mrs_addr),
    .mrs_bank(mrs_bank), .banks_idle(banks_idle), .dpd(dpd),
    .mode(mode), .load_err(mrs_err)
  );

  bcs_beat_gen #(.COL_W(COL_W)) u_beat (
    .clk(clk), .rst(rst), .dpd(dpd), .cmd_en(cmd_en), .cmd_col(cmd_col),
    .bl_code(mode.bl_code), .order(mode.order),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .bl_err(bl_err)
  );

  assign cas_lat = lat_cycles(mode.cl_code);
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             dpd,
  input logic             cmd_en,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic [1:0]       cas_lat,
  input logic             mrs_err,
  input logic             bl_err
);
  // R7: the last flag only marks a valid beat
  a_r7_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R7: with no new command, the burst ends after its last beat
  a_r7_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    (col_last && !cmd_en) |=> !col_valid);

  // R10: block bits never move within one burst
  a_r10_block_fixed: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !cmd_en) |=>
      (!col_valid || (col_out[COL_W-1:MAX_LOG] == $past(col_out[COL_W-1:MAX_LOG]))));

  // R6: a reserved-length command produces no beat
  a_r6_err_no_beat: assert property (@(posedge clk) disable iff (rst)
    bl_err |-> !col_valid);

  // R2: a rejected load leaves the latency untouched
  a_r2_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    mrs_err |-> $stable(cas_lat));

  // R4: deep power-down clears latency and beats
  a_r4_dpd_clears: assert property (@(posedge clk) disable iff (rst)
    dpd |=> (cas_lat == 2'd0) && !col_valid);

  // R5: the latency output stays in its legal set
  a_r5_lat_set: assert property (@(posedge clk) disable iff (rst)
    cas_lat != 2'd1);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .dpd(dpd), .cmd_en(cmd_en), .col_out(col_out),
  .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat),
  .mrs_err(mrs_err), .bl_err(bl_err)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mrs_en = 1'b0;
  logic [10:0] mrs_addr = '0;
  logic [1:0]  mrs_bank = '0;
  logic        banks_idle = 1'b1;
  logic        dpd = 1'b0;
  logic        cmd_en = 1'b0;
  logic [7:0]  cmd_col = '0;
  logic [7:0]  col_out;
  logic        col_valid, col_last, mrs_err, bl_err;
  logic [1:0]  cas_lat;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst(rst), .mrs_en(mrs_en), .mrs_addr(mrs_addr),
    .mrs_bank(mrs_bank), .banks_idle(banks_idle), .dpd(dpd),
    .cmd_en(cmd_en), .cmd_col(cmd_col), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat),
    .mrs_err(mrs_err), .bl_err(bl_err)
  );

  // {order, length code, start column}
  localparam logic [11:0] VEC [0:8] = '{
    12'h135, 12'h25E, 12'h32B, 12'h4C9, 12'hA13,
    12'hB7D, 12'hCA6, 12'h9FF, 12'h400
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b100: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] beat(input logic [7:0] s, input int len,
                                     input bit il, input int i);
    logic [7:0] m;
    m = 8'(len - 1);
    if (il) return (s & ~m) | ((s ^ 8'(i)) & m);
    return (s & ~m) | ((s + 8'(i)) & m);
  endfunction

  task automatic load(input logic [10:0] a, input logic [1:0] b);
    @(negedge clk);
    mrs_en = 1'b1; mrs_addr = a; mrs_bank = b;
    @(negedge clk);
    mrs_en = 1'b0; mrs_bank = '0;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_en = 1'b1; cmd_col = c;
    @(negedge clk);
    cmd_en = 1'b0;
  endtask

  task automatic run_burst(input bit il, input logic [2:0] code, input logic [7:0] s);
    int len;
    len = blen(code);
    load({4'b0, 3'b011, il, code}, 2'b00);
    issue(s);
    for (int i = 0; i < len; i++) begin
      logic [7:0] e;
      e = beat(s, len, il, i);
      check(col_valid && col_out == e && col_last == (i == len - 1),
            il ? "R9/R10 interleaved beat" : "R8/R10 sequential beat",
            {col_valid, col_last, col_out}, {1'b1, (i == len - 1), e});
      @(negedge clk);
    end
    check(!col_valid, "R7 burst length", col_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!col_valid && !col_last && !mrs_err && !bl_err && cas_lat == 0,
          "R12 reset", {col_valid, col_last, mrs_err, bl_err, cas_lat}, 0);

    // R6: reserved length code 000 after reset
    issue(8'h20);
    check(bl_err && !col_valid, "R6 reserved length after reset", {bl_err, col_valid}, 2'b10);

    // R1, R5: legal load, latency 3 then 2
    load(11'b0000_011_0_010, 2'b00);
    check(cas_lat == 3 && !mrs_err, "R1 R5 load latency 3", cas_lat, 3);
    load(11'b0000_010_0_010, 2'b00);
    check(cas_lat == 2, "R5 latency 2", cas_lat, 2);

    // R5 reserved latency codes
    load(11'b0000_001_0_010, 2'b00);
    check(cas_lat == 0, "R5 reserved 001", cas_lat, 0);
    load(11'b0000_100_0_010, 2'b00);
    check(cas_lat == 0, "R5 reserved 100", cas_lat, 0);

    // R2: load with a bank busy
    load(11'b0000_011_0_010, 2'b00);
    banks_idle = 1'b0;
    load(11'b0000_010_0_010, 2'b00);
    check(mrs_err && cas_lat == 3, "R2 busy load rejected", {mrs_err, cas_lat}, 3'b111);
    banks_idle = 1'b1;
    // R2: reserved upper bit set
    load(11'b0010_010_0_010, 2'b00);
    check(mrs_err && cas_lat == 3, "R2 reserved bits rejected", {mrs_err, cas_lat}, 3'b111);
    // R3: nonzero bank field
    load(11'b0000_010_0_010, 2'b01);
    check(!mrs_err && cas_lat == 3, "R3 other bank ignored", {mrs_err, cas_lat}, 3'b011);

    // R7, R8, R9, R10 table walk
    for (int k = 0; k < 9; k++)
      run_burst(VEC[k][11], VEC[k][10:8], VEC[k][7:0]);

    // R6: reserved length code 101
    load(11'b0000_011_0_101, 2'b00);
    issue(8'h44);
    check(bl_err && !col_valid, "R6 reserved length 101", {bl_err, col_valid}, 2'b10);

    // R11 restart mid-burst
    load(11'b0000_011_0_011, 2'b00);
    issue(8'h40);
    check(col_valid && col_out == 8'h40, "R11 first burst beat0", col_out, 8'h40);
    @(negedge clk);
    check(col_out == 8'h41, "R11 first burst beat1", col_out, 8'h41);
    issue(8'h93);
    check(col_valid && col_out == 8'h93, "R11 restart beat0", col_out, 8'h93);
    @(negedge clk);
    check(col_out == 8'h94 && !col_last, "R11 restart beat1", col_out, 8'h94);

    // R4 deep power-down mid-burst
    load(11'b0000_010_0_010, 2'b00);
    issue(8'h10);
    dpd = 1'b1;
    @(negedge clk);
    check(!col_valid && cas_lat == 0, "R4 dpd clears", {col_valid, cas_lat}, 0);
    dpd = 1'b0;
    issue(8'h10);
    check(bl_err && !col_valid, "R4 register cleared by dpd", {bl_err, col_valid}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule